// File: doc/BRIEF.md
# Butterfly Multiply-Accumulate with Rounded Shift

This execution unit performs one step of a two-output butterfly used in FFT and DCT kernels. It takes a signed multiplicand pair, forms their product and keeps the low word. It then adds that word to one accumulator operand and subtracts it from a second, paired accumulator in the same cycle. Both results can then share a round-half-up arithmetic right shift.

A typical sequence runs in two steps. An earlier pass leaves `a*c1 + b*c1` and `a*c1 - b*c1` in the two accumulators without any shift. This unit then adds and subtracts `b*(c2-c1)` and scales both results in one step. The unit sees only operand values and control fields. Register numbering and decode belong to the surrounding pipeline. A reserved-form flag marks the operation as illegal. When that flag is set, the result registers are left untouched.

Top module: `bfly_macc_round`

## Requirements
- R1: The product is the signed product of `in_ra` and `in_rb`, reduced to its low XLEN bits. The sum lane is `in_rt` plus that word and the difference lane is `in_rs` minus it, both modulo 2^XLEN.
- R2: When `in_sh` is 0, `out_rt` and `out_rs` carry the two lane values exactly, with no rounding constant added.
- R3: When `in_sh` = n with n > 0, each lane value first gets 2^(n-1) added, modulo 2^XLEN. It is then shifted right by n, and its low XLEN-n bits come from the rounded value.
- R4: When n > 0, the top n bits of each output are copies of bit XLEN-1 of the rounded value. This sign is taken after the rounding constant is added, so a rounding carry into the top bit gives a negative result.
- R5: When `in_rc` is 1 on an accepted operation, the result is reported with `out_illegal` = 1, and `out_rt` and `out_rs` keep their previous values. When `in_rc` is 0, `out_illegal` is 0.
- R6: An operation accepted with `in_valid` = 1 yields `out_valid` = 1 on the next cycle. A cycle without `in_valid` yields `out_valid` = 0 on the next cycle.
- R7: After reset, `out_valid`, `out_illegal`, `out_rt` and `out_rs` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| in_rt | input | XLEN | Accumulator receiving the sum |
| in_rs | input | XLEN | Paired accumulator receiving the difference |
| in_ra | input | XLEN | Signed multiplicand |
| in_rb | input | XLEN | Signed multiplier |
| in_sh | input | $clog2(XLEN) | Right shift amount n |
| in_rc | input | 1 | Reserved-form flag; 1 makes the operation illegal |
| out_valid | output | 1 | Result present |
| out_rt | output | XLEN | Updated sum accumulator |
| out_rs | output | XLEN | Updated difference accumulator |
| out_illegal | output | 1 | Last accepted operation was illegal |

## Verification
The hardest case to reach is the rounding constant carrying into the top bit. For that, a lane value must sit just below the positive limit with exactly the right low bits, and random operands almost never produce it. The stimulus therefore builds it directly: it picks accumulator values with a zero product so that the lane value is 0x7FFF...FFFF, then applies shifts of 1 and 63. Separate directed cases cover wraparound of the accumulators, and a long random run with fixed seed mixes in illegal operations to test that the outputs hold their values.

// File: rtl/bfly_pkg.sv
package bfly_pkg;
  localparam int unsigned BFLY_DEFAULT_XLEN = 64;
  localparam int unsigned BFLY_LANES = 2;

  typedef enum logic {
    LANE_SUM  = 1'b0,
    LANE_DIFF = 1'b1
  } bfly_lane_e;
endpackage

// File: rtl/bfly_mac.sv
module bfly_mac #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [XLEN-1:0] acc_a,
  input  logic [XLEN-1:0] acc_b,
  input  logic [XLEN-1:0] mul_x,
  input  logic [XLEN-1:0] mul_y,
  output logic [XLEN-1:0] lane_sum,
  output logic [XLEN-1:0] lane_diff
);
  localparam int PW = 2 * XLEN;

  // Signed product, kept to the low word.
  function automatic logic [XLEN-1:0] prod_low(input logic [XLEN-1:0] x,
                                               input logic [XLEN-1:0] y);
    logic signed [PW-1:0] full;
    full = $signed(x) * $signed(y);
    return full[XLEN-1:0];
  endfunction

  logic [XLEN-1:0] prod_w;

  always_comb begin
    prod_w    = prod_low(mul_x, mul_y);
    lane_sum  = acc_a + prod_w;
    lane_diff = acc_b - prod_w;
  end

  // R1: the product is added on one lane and removed on the other, so the
  // total of the lanes equals the total of the accumulators.
  p_lane_total_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_sum + lane_diff) == (acc_a + acc_b));
endmodule

// File: rtl/bfly_rshift.sv
module bfly_rshift #(
  parameter int XLEN = 64,
  parameter int SHW  = $clog2(XLEN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [XLEN-1:0] value_in,
  input  logic [SHW-1:0]  amt,
  output logic [XLEN-1:0] value_out,
  output logic            rounded_sign
);
  localparam logic [XLEN-1:0] ONE  = {{(XLEN-1){1'b0}}, 1'b1};
  localparam logic [XLEN-1:0] ONES = {XLEN{1'b1}};

  function automatic logic [XLEN-1:0] rotl(input logic [XLEN-1:0] x, input int k);
    return (x << k) | (x >> (XLEN - k));
  endfunction

  function automatic logic [XLEN-1:0] half_lsb(input logic [SHW-1:0] k);
    return (ONE << k) >> 1;
  endfunction

  logic            shift_en;
  logic [XLEN-1:0] rounded;
  logic [XLEN-1:0] keep_mask;
  logic [XLEN-1:0] kept;
  logic [XLEN-1:0] fill;

  always_comb begin
    shift_en     = (amt != '0);
    rounded      = value_in + half_lsb(amt);
    rounded_sign = rounded[XLEN-1];
    keep_mask    = ONES >> amt;
    kept         = rotl(rounded, XLEN - int'(amt)) & keep_mask;
    fill         = {XLEN{rounded_sign}} & ~keep_mask;
    value_out    = shift_en ? (kept | fill) : value_in;
  end

  // R2: no shift means the lane value passes unchanged.
  p_unshifted_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (amt == '0) |-> (value_out == value_in));
  // R4: with a shift the result's top bit is the post-rounding sign.
  p_sign_after_round_r4: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |-> (value_out[XLEN-1] == rounded_sign));
endmodule

// File: rtl/bfly_macc_round.sv
module bfly_macc_round
  import bfly_pkg::*;
#(
  parameter  int XLEN = BFLY_DEFAULT_XLEN,
  localparam int SHW  = $clog2(XLEN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [XLEN-1:0] in_rt,
  input  logic [XLEN-1:0] in_rs,
  input  logic [XLEN-1:0] in_ra,
  input  logic [XLEN-1:0] in_rb,
  input  logic [SHW-1:0]  in_sh,
  input  logic            in_rc,
  output logic            out_valid,
  output logic [XLEN-1:0] out_rt,
  output logic [XLEN-1:0] out_rs,
  output logic            out_illegal
);
  logic [XLEN-1:0] lane_pre  [BFLY_LANES];
  logic [XLEN-1:0] lane_post [BFLY_LANES];
  logic            lane_sign [BFLY_LANES];
  logic            accept_ok;
  logic            accept_bad;

  bfly_mac #(.XLEN(XLEN)) u_mac (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_a    (in_rt),
    .acc_b    (in_rs),
    .mul_x    (in_ra),
    .mul_y    (in_rb),
    .lane_sum (lane_pre[LANE_SUM]),
    .lane_diff(lane_pre[LANE_DIFF])
  );

  for (genvar g = 0; g < BFLY_LANES; g++) begin : g_lane
    bfly_rshift #(.XLEN(XLEN), .SHW(SHW)) u_shift (
      .clk         (clk),
      .rst_n       (rst_n),
      .value_in    (lane_pre[g]),
      .amt         (in_sh),
      .value_out   (lane_post[g]),
      .rounded_sign(lane_sign[g])
    );
  end

  assign accept_ok  = in_valid && !in_rc;
  assign accept_bad = in_valid && in_rc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_illegal <= 1'b0;
      out_rt      <= '0;
      out_rs      <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_illegal <= in_rc;
      if (accept_ok) begin
        out_rt <= lane_post[LANE_SUM];
        out_rs <= lane_post[LANE_DIFF];
      end
    end
  end

  // R6: one-cycle latency, no spurious valid.
  p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R5: reserved form flags illegal and leaves the results alone.
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    accept_bad |=> (out_illegal && $stable(out_rt) && $stable(out_rs)));
  p_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    accept_ok |=> !out_illegal);
  // R4: a registered shifted result keeps the lane's post-rounding sign.
  p_out_sign_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_ok && in_sh != '0) |=> (out_rt[XLEN-1] == $past(lane_sign[LANE_SUM])));
endmodule

// File: tb/bfly_macc_round_test.sv
module bfly_macc_round_test;
  localparam int XLEN = 64;
  localparam int SHW  = 6;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic [XLEN-1:0] in_rt = '0, in_rs = '0, in_ra = '0, in_rb = '0;
  logic [SHW-1:0]  in_sh = '0;
  logic            in_rc = 1'b0;
  logic            out_valid, out_illegal;
  logic [XLEN-1:0] out_rt, out_rs;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [XLEN-1:0] exp_rt = '0, exp_rs = '0;

  always #10 clk = ~clk;

  bfly_macc_round uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_rt(in_rt), .in_rs(in_rs),
    .in_ra(in_ra), .in_rb(in_rb), .in_sh(in_sh), .in_rc(in_rc),
    .out_valid(out_valid), .out_rt(out_rt), .out_rs(out_rs), .out_illegal(out_illegal)
  );

  // Reference: low word of a*b is the same for signed and unsigned forms.
  function automatic logic [XLEN-1:0] ref_lane(input logic [XLEN-1:0] acc,
      input logic [XLEN-1:0] a, input logic [XLEN-1:0] b, input bit minus,
      input int n);
    logic [XLEN-1:0] p, v;
    p = a * b;
    v = minus ? acc - p : acc + p;
    if (n == 0) return v;
    v = v + (64'd1 << (n - 1));
    return $signed(v) >>> n;
  endfunction

  task automatic check(input string req, input logic [XLEN-1:0] act,
                       input logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [XLEN-1:0] rt, input logic [XLEN-1:0] rs,
      input logic [XLEN-1:0] ra, input logic [XLEN-1:0] rb, input int n,
      input bit rc, input string req);
    @(negedge clk);
    in_valid = 1'b1; in_rt = rt; in_rs = rs; in_ra = ra; in_rb = rb;
    in_sh = SHW'(n); in_rc = rc;
    if (!rc) begin
      exp_rt = ref_lane(rt, ra, rb, 1'b0, n);
      exp_rs = ref_lane(rs, ra, rb, 1'b1, n);
    end
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " R6 valid"}, {63'd0, out_valid}, 64'd1);
    check({req, " R5 illegal flag"}, {63'd0, out_illegal}, {63'd0, rc});
    check({req, " rt"}, out_rt, exp_rt);
    check({req, " rs"}, out_rs, exp_rs);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'h5eed_b0f1));
    repeat (3) @(negedge clk);
    // R7 reset state
    check("R7 out_valid", {63'd0, out_valid}, 64'd0);
    check("R7 out_illegal", {63'd0, out_illegal}, 64'd0);
    check("R7 out_rt", out_rt, 64'd0);
    check("R7 out_rs", out_rs, 64'd0);
    rst_n = 1'b1;

    run_op(64'd100, 64'd100, 64'd7, -64'sd3, 0, 1'b0, "R1 R2 sh0 signed product");
    run_op(64'd10, 64'd11, 64'd1, 64'd4, 1, 1'b0, "R3 sh1 round");
    run_op(-64'sd9, 64'd9, 64'd2, 64'd1, 1, 1'b0, "R3 sh1 negative");
    run_op(64'h7FFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, 64'd5, 64'd3, 0, 1'b0,
           "R1 wraparound");
    run_op(64'h4000_0000_0000_0000, 64'd0, 64'h7FFF_FFFF_FFFF_FFFF, 64'd2, 63, 1'b0,
           "R3 sh63");
    // R4: rounding carries into the sign bit
    run_op(64'h7FFF_FFFF_FFFF_FFFF, 64'h7FFF_FFFF_FFFF_FFFF, 64'd0, 64'd9, 1, 1'b0,
           "R4 sign flip sh1");
    check("R4 sign flip value", out_rt, 64'hC000_0000_0000_0000);
    run_op(64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 64'd0, 64'd9, 63, 1'b0, "R4 sign flip sh63");
    check("R4 sign flip sh63 value", out_rt, 64'hFFFF_FFFF_FFFF_FFFF);
    // R5: illegal leaves results unchanged
    run_op(64'd1, 64'd2, 64'd3, 64'd4, 0, 1'b1, "R5 reserved hold");
    run_op(64'd1, 64'd2, 64'd3, 64'd4, 0, 1'b0, "R5 legal after illegal");
    // R6: idle cycle
    @(negedge clk);
    check("R6 idle", {63'd0, out_valid}, 64'd0);

    for (int i = 0; i < 400; i++) begin
      automatic logic [XLEN-1:0] r1 = {$urandom(), $urandom()};
      automatic logic [XLEN-1:0] r2 = {$urandom(), $urandom()};
      automatic logic [XLEN-1:0] r3 = {$urandom(), $urandom()};
      automatic logic [XLEN-1:0] r4 = {$urandom(), $urandom()};
      automatic int sh = int'($urandom_range(0, 63));
      automatic bit rc = ($urandom_range(0, 7) == 0);
      if (i % 3 == 0) r3 = r3 >> 40;
      run_op(r1, r2, r3, r4, sh, rc, "R1 R3 R5 random");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule